// File: doc/BRIEF.md
# DMA Channel Transfer Controller

This block is the control engine of one DMA channel. Software programs a control word, a unit count and a source/destination address pair through a simple register port. The channel then waits for a qualified transfer request. The request can come from an active-low external line or from an on-chip requester. For every unit it moves data with a read beat from the source followed by a write beat to the destination, on a plain bus-request/grant port.

Each unit is 1, 2, 4 or 16 bytes. A 16-byte unit runs as four longword read/write pairs and counts once against the unit count. In cycle-steal mode the bus is given back after every unit. In burst mode the bus is kept until the count runs out. When the count reaches zero a sticky end flag is raised, and an interrupt follows it if interrupts are enabled. A parameter marks the instance as channel 0. Only channel 0 can choose falling-edge detection of the external line.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0 (channel disabled, level detection, cycle-steal, byte size, interrupt off, end flag clear), the count reads 0, and bus_req and irq are 0.
- R2: Control word bits: [0] enable, [1] end flag, [2] interrupt enable, [4:3] size (00 byte, 01 word, 10 longword, 11 16-byte unit), [5] bus mode (0 cycle-steal, 1 burst), [6] edge select (0 low level, 1 falling edge), [7] request source (0 external pin, 1 internal requester). Register select on reg_sel/rd_sel: 0 control, 1 count, 2 source address, 3 destination address.
- R3: Each unit is a read beat at the source address, then a write beat at the destination address. The bus size code is 00, 01 or 10 for byte, word or longword, and 10 for each beat of a 16-byte unit. No beat is issued unless bus_req and bus_gnt are both high.
- R4: Both addresses advance by 1, 2 or 4 bytes per beat for byte, word or longword, so a 16-byte unit of four beats advances them by 16. The count decrements by one per completed unit.
- R5: In cycle-steal mode bus_req falls after every unit, so N units produce N separate bus_req assertions. In burst mode one request runs all N units under a single bus_req assertion.
- R6: When the count reaches zero the end flag is set. It stays set until software writes 0 to bit 1, and writing 1 to that bit has no effect.
- R7: While the end flag is set, or while the channel is disabled, requests start no transfers.
- R8: irq equals end flag AND interrupt enable. With interrupt enable 0, completion raises no irq.
- R9: With edge select 1 on channel 0, each high-to-low transition of dreq_n, after a two-flop synchroniser, starts exactly one unit, however long the line stays low.
- R10: With edge select 0, a unit starts whenever the channel is idle and dreq_n is seen low.
- R11: On an instance that is not channel 0, control bit 6 always reads 0 and writes to it are ignored, so the external line is level sensitive.
- R12: With request source 1, int_req (active high) is the request, and detection is always level-based whatever bit 6 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selected for write |
| reg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | 32 | Read data of the selected register |
| dreq_n | input | 1 | External transfer request, active low, asynchronous |
| int_req | input | 1 | On-chip transfer request, active high |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| xfer_valid | output | 1 | Beat valid |
| xfer_write | output | 1 | Beat direction, 1 for write |
| xfer_addr | output | 32 | Beat address |
| xfer_size | output | 2 | Beat size code |
| xfer_ready | input | 1 | Beat accepted |
| irq | output | 1 | Completion interrupt |

## Verification
Several properties are checked on every cycle: no beat appears without grant, the size code 11 never reaches the bus, irq never appears without the end flag, the count only moves down by one apart from software writes, and the end flag never drops without a clearing write. The bench scenarios are what show that the address steps and beat counts are right for each size, and that cycle-steal and burst modes differ in how many bus requests they make. They also show that one edge gives one unit, that a non-zero channel discards the edge select, and that the internal requester works.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BLK16 = 2'b11
    } unit_size_e;

    typedef struct packed {
        logic       isrc;
        logic       edge_sel;
        logic       burst;
        unit_size_e size;
        logic       ie;
        logic       te;
        logic       en;
    } chan_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARB  = 2'b01,
        ST_RD   = 2'b10,
        ST_WR   = 2'b11
    } eng_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_SRC  = 2'd2;
    localparam logic [1:0] SEL_DST  = 2'd3;

endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    input  logic allow,
    input  logic consume,
    output logic low_seen,
    output logic pending
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
    } det_t;

    det_t cur_q, nxt_d;
    logic fall;

    assign fall = cur_q.prev & ~cur_q.sync[SYNC_STAGES-1];

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sync = {cur_q.sync[SYNC_STAGES-2:0], dreq_n};
        nxt_d.prev = cur_q.sync[SYNC_STAGES-1];
        nxt_d.pend = allow & (fall | (cur_q.pend & ~consume));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{sync: '1, prev: 1'b1, pend: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign low_seen = ~cur_q.sync[SYNC_STAGES-1];
    assign pending  = cur_q.pend;

    // R9
    edge_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter bit          IS_CH0 = 1'b1,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              beat_done,
    input  logic              unit_done,
    input  logic              set_te,
    output chan_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

    typedef struct packed {
        chan_ctrl_t        ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic [ADDR_W-1:0] step;
    logic              ds_wr;

    generate
        if (IS_CH0) begin : g_ds_live
            assign ds_wr = reg_wdata[6];
        end else begin : g_ds_fixed
            assign ds_wr = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (cur_q.ctrl.size)
            SZ_BYTE: step = ADDR_W'(1);
            SZ_WORD: step = ADDR_W'(2);
            default: step = ADDR_W'(4);
        endcase
    end

    always_comb begin
        nxt_d = cur_q;
        if (beat_done) begin
            nxt_d.src = cur_q.src + step;
            nxt_d.dst = cur_q.dst + step;
        end
        if (unit_done) begin
            nxt_d.cnt = cur_q.cnt - CNT_W'(1);
        end
        if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    nxt_d.ctrl.en       = reg_wdata[0];
                    nxt_d.ctrl.te       = cur_q.ctrl.te & reg_wdata[1];
                    nxt_d.ctrl.ie       = reg_wdata[2];
                    nxt_d.ctrl.size     = unit_size_e'(reg_wdata[4:3]);
                    nxt_d.ctrl.burst    = reg_wdata[5];
                    nxt_d.ctrl.edge_sel = ds_wr;
                    nxt_d.ctrl.isrc     = reg_wdata[7];
                end
                SEL_CNT: nxt_d.cnt = reg_wdata[CNT_W-1:0];
                SEL_SRC: nxt_d.src = reg_wdata[ADDR_W-1:0];
                default: nxt_d.dst = reg_wdata[ADDR_W-1:0];
            endcase
        end
        if (set_te) begin
            nxt_d.ctrl.te = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL: rd_data = DATA_W'({cur_q.ctrl});
            SEL_CNT:  rd_data = DATA_W'(cur_q.cnt);
            SEL_SRC:  rd_data = DATA_W'(cur_q.src);
            default:  rd_data = DATA_W'(cur_q.dst);
        endcase
    end

    assign ctrl     = cur_q.ctrl;
    assign count    = cur_q.cnt;
    assign src_addr = cur_q.src;
    assign dst_addr = cur_q.dst;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(reg_we && reg_sel == SEL_CNT)) && cur_q.cnt != $past(cur_q.cnt))
        |-> cur_q.cnt == $past(cur_q.cnt) - CNT_W'(1));

    // R6
    te_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ctrl.te && !(reg_we && reg_sel == SEL_CTRL && !reg_wdata[1]))
        |=> cur_q.ctrl.te);

    // R11
    ds_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_CH0 |-> !cur_q.ctrl.edge_sel);

    logic unused_ok;
    assign unused_ok = ^{reg_wdata, CTRL_W[0]};
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_chan_pkg::*;
#(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned BLK_BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       burst,
    input  unit_size_e size,
    input  logic [CNT_W-1:0] count,
    input  logic       bus_gnt,
    input  logic       xfer_ready,
    output logic       bus_req,
    output logic       xfer_valid,
    output logic       xfer_write,
    output logic [1:0] xfer_size,
    output logic       start,
    output logic       beat_done,
    output logic       unit_done,
    output logic       set_te
);
    localparam int unsigned BEAT_W = $clog2(BLK_BEATS);

    typedef struct packed {
        eng_state_e        st;
        logic [BEAT_W-1:0] beat;
    } eng_t;

    eng_t cur_q, nxt_d;
    logic last_beat;

    assign last_beat = (size != SZ_BLK16) || (cur_q.beat == BEAT_W'(BLK_BEATS-1));

    always_comb begin
        nxt_d      = cur_q;
        start      = 1'b0;
        beat_done  = 1'b0;
        unit_done  = 1'b0;
        set_te     = 1'b0;
        bus_req    = 1'b0;
        xfer_valid = 1'b0;
        xfer_write = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (go) begin
                    start    = 1'b1;
                    nxt_d.st = ST_ARB;
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    nxt_d.st   = ST_RD;
                    nxt_d.beat = '0;
                end
            end
            ST_RD: begin
                bus_req    = 1'b1;
                xfer_valid = bus_gnt;
                if (bus_gnt && xfer_ready) begin
                    nxt_d.st = ST_WR;
                end
            end
            default: begin
                bus_req    = 1'b1;
                xfer_valid = bus_gnt;
                xfer_write = 1'b1;
                if (bus_gnt && xfer_ready) begin
                    beat_done = 1'b1;
                    if (!last_beat) begin
                        nxt_d.beat = cur_q.beat + BEAT_W'(1);
                        nxt_d.st   = ST_RD;
                    end else begin
                        unit_done  = 1'b1;
                        nxt_d.beat = '0;
                        if (count == CNT_W'(1)) begin
                            set_te   = 1'b1;
                            nxt_d.st = ST_IDLE;
                        end else if (burst) begin
                            nxt_d.st = ST_RD;
                        end else begin
                            nxt_d.st = ST_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, beat: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign xfer_size = (size == SZ_BLK16) ? 2'b10 : size;

    // R3
    beat_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (bus_req && bus_gnt));

    // R3
    no_size11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_size != 2'b11);

    // R5
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && !burst) |=> !bus_req);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter bit          IS_CH0 = 1'b1,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        dreq_n,
    input  logic        int_req,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        xfer_valid,
    output logic        xfer_write,
    output logic [31:0] xfer_addr,
    output logic [1:0]  xfer_size,
    input  logic        xfer_ready,
    output logic        irq
);
    chan_ctrl_t        ctrl;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic beat_done, unit_done, set_te, start;
    logic low_seen, pending, allow, use_edge, req, go;

    dma_chan_regs #(.IS_CH0(IS_CH0), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .beat_done(beat_done), .unit_done(unit_done), .set_te(set_te),
        .ctrl(ctrl), .count(count), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    assign allow    = ctrl.en & ~ctrl.te;
    assign use_edge = IS_CH0 & ctrl.edge_sel & ~ctrl.isrc;

    dma_req_detect #(.SYNC_STAGES(2)) u_det (
        .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n),
        .allow(allow), .consume(start),
        .low_seen(low_seen), .pending(pending)
    );

    always_comb begin
        if (ctrl.isrc)      req = int_req;
        else if (use_edge)  req = pending;
        else                req = low_seen;
    end

    assign go = allow & req & (count != '0);

    dma_xfer_engine #(.CNT_W(CNT_W), .BLK_BEATS(4)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .burst(ctrl.burst), .size(ctrl.size),
        .count(count), .bus_gnt(bus_gnt), .xfer_ready(xfer_ready),
        .bus_req(bus_req), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .xfer_size(xfer_size), .start(start), .beat_done(beat_done),
        .unit_done(unit_done), .set_te(set_te)
    );

    assign xfer_addr = 32'(xfer_write ? dst_addr : src_addr);
    assign irq       = ctrl.te & ctrl.ie;

    // R8
    irq_needs_te_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl.te);

    // R7
    blocked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.te || !ctrl.en) |-> !start);
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic        dreq_n = 1'b1, int_req = 1'b0;
    logic        dreq1_n = 1'b1;
    logic [31:0] rd_data, rd1_data, xfer_addr, xfer1_addr;
    logic        bus_req, xfer_valid, xfer_write, irq;
    logic        bus1_req, xfer1_valid, xfer1_write, irq1;
    logic [1:0]  xfer_size, xfer1_size;
    logic        we1 = 1'b0;

    dma_chan_ctrl #(.IS_CH0(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .dreq_n(dreq_n), .int_req(int_req), .bus_req(bus_req), .bus_gnt(bus_req),
        .xfer_valid(xfer_valid), .xfer_write(xfer_write), .xfer_addr(xfer_addr),
        .xfer_size(xfer_size), .xfer_ready(1'b1), .irq(irq)
    );

    dma_chan_ctrl #(.IS_CH0(1'b0)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .reg_we(we1), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd1_data),
        .dreq_n(dreq1_n), .int_req(1'b0), .bus_req(bus1_req), .bus_gnt(bus1_req),
        .xfer_valid(xfer1_valid), .xfer_write(xfer1_write), .xfer_addr(xfer1_addr),
        .xfer_size(xfer1_size), .xfer_ready(1'b1), .irq(irq1)
    );

    int total = 0, bad = 0;
    int n_rd, n_wr, n_rise, n1_wr;
    logic [31:0] last_rd, last_wr, first_wr;
    logic        size_bad, prev_req;
    logic [1:0]  exp_size;

    always @(negedge clk) begin
        if (xfer_valid && !xfer_write) begin n_rd++; last_rd = xfer_addr; end
        if (xfer_valid && xfer_write) begin
            if (n_wr == 0) first_wr = xfer_addr;
            n_wr++; last_wr = xfer_addr;
        end
        if (xfer_valid && xfer_size != exp_size) size_bad = 1'b1;
        if (bus_req && !prev_req) n_rise++;
        prev_req = bus_req;
        if (xfer1_valid && xfer1_write) n1_wr++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon(input logic [1:0] sz);
        n_rd = 0; n_wr = 0; n_rise = 0; n1_wr = 0; size_bad = 1'b0;
        last_rd = '0; last_wr = '0; first_wr = '0; exp_size = sz;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input bit ch1 = 0);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d;
        if (ch1) we1 = 1'b1; else reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; we1 = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d, input bit ch1 = 0);
        @(negedge clk);
        rd_sel = sel;
        #1 d = ch1 ? rd1_data : rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] cnt, input logic [31:0] src, input logic [31:0] dst);
        wr(2'd1, cnt); wr(2'd2, src); wr(2'd3, dst);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 count", d, 0);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_level_steal();
        logic [31:0] d;
        clr_mon(2'b00);
        setup(3, 32'h100, 32'h200);
        wr(2'd0, 32'h01);               // R2: en, byte, cycle-steal, ie=0
        dreq_n = 1'b0; idle(40); dreq_n = 1'b1;
        chk("R10 reads", n_rd, 3); chk("R3 writes", n_wr, 3);
        chk("R4 last dst", last_wr, 32'h202);
        chk("R5 steal requests", n_rise, 3);
        rd(2'd0, d); chk("R6 te set", d[1], 1);
        rd(2'd1, d); chk("R4 count zero", d, 0);
        chk("R8 no irq ie=0", 32'(irq), 0);
        chk("R3 size", 32'(size_bad), 0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        clr_mon(2'b00);
        wr(2'd1, 2);
        wr(2'd0, 32'h03);               // write 1 to te: keep set
        dreq_n = 1'b0; idle(20); dreq_n = 1'b1;
        chk("R7 no xfer while te", n_wr, 0);
        rd(2'd1, d); chk("R7 count kept", d, 2);
        rd(2'd0, d); chk("R6 te kept", d[1], 1);
        wr(2'd0, 32'h00); rd(2'd0, d); chk("R6 te cleared", d[1], 0);
        idle(4);
    endtask

    task automatic t_word_burst();
        logic [31:0] d;
        clr_mon(2'b01);
        setup(4, 32'h1000, 32'h2000);
        wr(2'd0, 32'h2D);               // en, ie, word, burst
        dreq_n = 1'b0; idle(3); dreq_n = 1'b1; idle(30);
        chk("R5 burst one request", n_rise, 1);
        chk("R4 word writes", n_wr, 4);
        chk("R4 word last dst", last_wr, 32'h2006);
        chk("R4 word last src", last_rd, 32'h1006);
        chk("R8 irq", 32'(irq), 1);
        chk("R3 word size", 32'(size_bad), 0);
        wr(2'd0, 32'h00);
        chk("R8 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_blk16();
        logic [31:0] d;
        clr_mon(2'b10);
        setup(2, 32'h40, 32'h80);
        wr(2'd0, 32'h19);               // en, 16-byte, steal
        dreq_n = 1'b0; idle(40); dreq_n = 1'b1;
        chk("R3 blk reads", n_rd, 8);
        chk("R3 blk writes", n_wr, 8);
        chk("R4 blk last dst", last_wr, 32'h9C);
        rd(2'd2, d); chk("R4 blk src end", d, 32'h60);
        rd(2'd1, d); chk("R4 blk count", d, 0);
        chk("R5 blk requests", n_rise, 2);
        chk("R3 blk size", 32'(size_bad), 0);
        wr(2'd0, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        clr_mon(2'b10);
        setup(5, 32'h0, 32'h10);
        wr(2'd0, 32'h51);               // en, long, edge
        rd(2'd0, d); chk("R9 ds readback", d[6], 1);
        dreq_n = 1'b0; idle(30); dreq_n = 1'b1; idle(5);
        dreq_n = 1'b0; idle(4); dreq_n = 1'b1; idle(20);
        chk("R9 one unit per edge", n_wr, 2);
        rd(2'd1, d); chk("R9 count", d, 3);
        wr(2'd0, 0);
    endtask

    task automatic t_internal();
        logic [31:0] d;
        clr_mon(2'b00);
        setup(2, 32'h0, 32'h10);
        wr(2'd0, 32'hC1);               // en, isrc, edge bit set
        int_req = 1'b1; idle(25); int_req = 1'b0;
        chk("R12 level on int_req", n_wr, 2);
        rd(2'd0, d); chk("R12 te", d[1], 1);
        wr(2'd0, 0);
    endtask

    task automatic t_other_ch();
        logic [31:0] d;
        clr_mon(2'b00);
        wr(2'd1, 3, 1'b1);
        wr(2'd0, 32'h41, 1'b1);         // en + edge request on channel 1
        rd(2'd0, d, 1'b1); chk("R11 ds reads 0", d[6], 0);
        dreq1_n = 1'b0; idle(40); dreq1_n = 1'b1;
        chk("R11 level units", n1_wr, 3);
    endtask

    initial begin
        fork
            begin
                clr_mon(2'b00);
                prev_req = 1'b0;
                idle(3); rst_n = 1'b1; idle(2);
                t_reset();
                t_level_steal();
                t_sticky();
                t_word_burst();
                t_blk16();
                t_edge();
                t_internal();
                t_other_ch();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule